// File: doc/BRIEF.md
# Bus-Activity Watchdog and Reset Generator

This block drives the system reset line of a supply supervisor. Reset is held at power-on and after any low-supply indication. It is released only once the supply flag has stayed clear for one full, unbroken power-on interval. A watchdog runs in parallel and supervises the host processor. The host proves it is alive by issuing a START condition on the two-wire serial bus, meaning SDA falls while SCL is high. If the selected watchdog period passes with no START, a fixed-length reset pulse is issued.

The SCL and SDA samples pass through a two-flop synchronizer before edge detection. A 2-bit code picks one of three watchdog periods or turns the watchdog off. Every interval is a parameter counted in clock ticks, so it can be scaled down for simulation. When reset becomes active from the idle state, a one-cycle abort strobe tells the bus logic to drop any transfer in flight. A parameter chooses whether the reset output is active-high or active-low.

Top module: `bus_wdt_reset_gen`

## Requirements
- R1: While rst_ni is low, reset is active. After rst_ni rises with supply_low_i clear, reset stays active for exactly POR_TICKS clock cycles, counting the cycle in which rst_ni rises.
- R2: A high level on supply_low_i makes reset active on the next clock edge. Reset is released POR_TICKS cycles after the first cycle in which the flag is seen clear.
- R3: The watchdog period code is wd_sel_i. Code 2'b00 selects WD_LONG_TICKS, 2'b01 selects WD_MID_TICKS and 2'b10 selects WD_SHORT_TICKS. With no START, reset stays released for exactly that many cycles.
- R4: Code 2'b11 disables the watchdog, so reset is never asserted by it. Leaving code 2'b11 starts a fresh period from zero.
- R5: A watchdog expiry holds reset active for exactly RST_TICKS cycles, after which reset is released.
- R6: A START restarts the watchdog period. A START is SDA going from 1 to 0 while SCL is 1, both seen after the two-flop synchronizer. When SDA falls at cycle K, the next expiry reset begins WD period + 3 cycles after K.
- R7: No other bus activity restarts the watchdog. This covers SDA changes while SCL is low, SCL toggling, and SDA rising while SCL is high.
- R8: The watchdog count is held at zero while reset is active, and a START during reset has no effect. After release, the full period elapses before the next expiry.
- R9: If supply_low_i is raised during a watchdog reset pulse, the pulse becomes a power-on hold. Release then needs POR_TICKS uninterrupted cycles with the flag clear.
- R10: bus_abort_o is high for exactly one cycle, and only in the first cycle that reset is active after being inactive. It stays low at power-on and when an event arrives during an active reset.
- R11: With RESET_ACTIVE_HIGH = 1, reset_o is high when active. With RESET_ACTIVE_HIGH = 0, reset_o is low when active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| scl_i | input | 1 | Serial clock line sample |
| sda_i | input | 1 | Serial data line sample |
| supply_low_i | input | 1 | Supply-below-trip comparator flag |
| wd_sel_i | input | 2 | Watchdog period code |
| reset_o | output | 1 | System reset, polarity set by RESET_ACTIVE_HIGH |
| bus_abort_o | output | 1 | One-cycle strobe to abort the serial transfer |

## Verification
Every cycle, the assertions check the following:
- a low-supply flag forces reset and clears the release timer on the next edge;
- the watchdog count stays at zero during reset and never passes its period;
- the disabled code never produces an expiry;
- the abort strobe is a single cycle and only marks the entry into reset.

Only the bench scenarios can show the exact durations. These are the power-on hold, each of the three periods, the pulse length and the three-cycle START latency. The bench also shows that non-START bus activity and START conditions during reset leave the timing unchanged.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  typedef enum logic {
    SRC_POWER = 1'b0,
    SRC_WDOG  = 1'b1
  } rst_src_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/bwr_sync.sv
module bwr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RESET_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bwr_start_det.sv
module bwr_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic block_i,
  output logic start_o
);
  logic sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_q <= 1'b1;
    else sda_q <= sda_s_i;
  end

  // falling SDA with SCL high; bus ignored while reset is active
  assign start_o = !block_i && scl_s_i && sda_q && !sda_s_i;
endmodule

// File: rtl/bwr_wdt.sv
module bwr_wdt
  import bwr_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1400,
  parameter int unsigned MID_TICKS   = 600,
  parameter int unsigned SHORT_TICKS = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wd_code_e   code_i,
  input  logic       hold_i,
  input  logic       kick_i,
  output logic       expire_o
);
  localparam int unsigned MaxTicks = max3(LONG_TICKS, MID_TICKS, SHORT_TICKS);
  localparam int unsigned CW = $clog2(MaxTicks + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          enabled;

  always_comb begin
    unique case (code_i)
      WD_LONG:  last = CW'(LONG_TICKS - 1);
      WD_MID:   last = CW'(MID_TICKS - 1);
      WD_SHORT: last = CW'(SHORT_TICKS - 1);
      default:  last = '0;
    endcase
  end

  assign enabled  = (code_i != WD_OFF);
  assign expire_o = enabled && !hold_i && !kick_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (hold_i || kick_i || !enabled || expire_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  a_r4_off_no_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_i == WD_OFF |-> !expire_o);
  a_r8_held_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == '0);
  a_r6_kick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_q == '0);
  a_r3_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MaxTicks));
endmodule

// File: rtl/bwr_reset_ctrl.sv
module bwr_reset_ctrl
  import bwr_pkg::*;
#(
  parameter int unsigned POR_TICKS = 250,
  parameter int unsigned RST_TICKS = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic expire_i,
  output logic active_o,
  output logic abort_o
);
  localparam int unsigned MaxTicks = (POR_TICKS > RST_TICKS) ? POR_TICKS : RST_TICKS;
  localparam int unsigned CW = $clog2(MaxTicks + 1);

  rst_src_e      src_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          active_q;
  logic          abort_q;

  assign last = (src_q == SRC_POWER) ? CW'(POR_TICKS - 1) : CW'(RST_TICKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      src_q    <= SRC_POWER;
      cnt_q    <= '0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (low_i) begin
        active_q <= 1'b1;
        src_q    <= SRC_POWER;
        cnt_q    <= '0;
        abort_q  <= !active_q;
      end else if (expire_i) begin
        active_q <= 1'b1;
        src_q    <= SRC_WDOG;
        cnt_q    <= '0;
        abort_q  <= !active_q;
      end else if (active_q) begin
        if (cnt_q >= last) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign abort_o  = abort_q;

  a_r2_low_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |=> active_o);
  a_r9_low_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |=> (cnt_q == '0) && (src_q == SRC_POWER));
  a_r10_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  a_r10_abort_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> active_o && !$past(active_o));
  a_r5_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MaxTicks));
endmodule

// File: rtl/bus_wdt_reset_gen.sv
module bus_wdt_reset_gen
  import bwr_pkg::*;
#(
  parameter int unsigned POR_TICKS        = 250000,
  parameter int unsigned RST_TICKS        = 250000,
  parameter int unsigned WD_LONG_TICKS    = 1400000,
  parameter int unsigned WD_MID_TICKS     = 600000,
  parameter int unsigned WD_SHORT_TICKS   = 200000,
  parameter bit          RESET_ACTIVE_HIGH = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       supply_low_i,
  input  logic [1:0] wd_sel_i,
  output logic       reset_o,
  output logic       bus_abort_o
);
  logic [1:0] bus_s;
  logic       start;
  logic       expire;
  logic       rst_active;

  bwr_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  bwr_start_det u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(bus_s[1]),
    .sda_s_i(bus_s[0]),
    .block_i(rst_active),
    .start_o(start)
  );

  bwr_wdt #(
    .LONG_TICKS (WD_LONG_TICKS),
    .MID_TICKS  (WD_MID_TICKS),
    .SHORT_TICKS(WD_SHORT_TICKS)
  ) u_wdt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .code_i  (wd_code_e'(wd_sel_i)),
    .hold_i  (rst_active),
    .kick_i  (start),
    .expire_o(expire)
  );

  bwr_reset_ctrl #(
    .POR_TICKS(POR_TICKS),
    .RST_TICKS(RST_TICKS)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .low_i   (supply_low_i),
    .expire_i(expire),
    .active_o(rst_active),
    .abort_o (bus_abort_o)
  );

  if (RESET_ACTIVE_HIGH) begin : g_pol_high
    assign reset_o = rst_active;
  end else begin : g_pol_low
    assign reset_o = !rst_active;
  end
endmodule

// File: tb/bus_wdt_reset_gen_test.sv
module bus_wdt_reset_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int POR = 40;
  localparam int RST = 25;
  localparam int WDL = 120;
  localparam int WDM = 70;
  localparam int WDS = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic low = 1'b0;
  logic [1:0] wd_sel = 2'b00;
  logic reset_lo, reset_hi, abort_lo, abort_hi;

  int checks = 0;
  int fails = 0;
  int pol_mismatch = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wdt_reset_gen #(.POR_TICKS(POR), .RST_TICKS(RST), .WD_LONG_TICKS(WDL),
    .WD_MID_TICKS(WDM), .WD_SHORT_TICKS(WDS), .RESET_ACTIVE_HIGH(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda), .supply_low_i(low),
    .wd_sel_i(wd_sel), .reset_o(reset_lo), .bus_abort_o(abort_lo));

  bus_wdt_reset_gen #(.POR_TICKS(POR), .RST_TICKS(RST), .WD_LONG_TICKS(WDL),
    .WD_MID_TICKS(WDM), .WD_SHORT_TICKS(WDS), .RESET_ACTIVE_HIGH(1'b1)) uut_hi (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda), .supply_low_i(low),
    .wd_sel_i(wd_sel), .reset_o(reset_hi), .bus_abort_o(abort_hi));

  always @(negedge clk) if (reset_hi !== ~reset_lo || abort_hi !== abort_lo) pol_mismatch++;

  function automatic bit on();
    return reset_lo == 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_active(output int n);
    n = 0;
    while (on() && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic count_inactive(output int n);
    n = 0;
    while (!on() && n < 5000) begin n++; @(negedge clk); end
  endtask

  // at first active sample of a watchdog pulse: strobe then length
  task automatic pulse_check(input string req);
    int n;
    chk(abort_lo == 1'b1, "R10 strobe on entry", int'(abort_lo), 1);
    @(negedge clk);
    chk(abort_lo == 1'b0, "R10 strobe single", int'(abort_lo), 0);
    count_active(n);
    chk(n == RST - 1, req, n + 1, RST);
  endtask

  function automatic int period(input int code);
    return (code == 0) ? WDL : (code == 1) ? WDM : WDS;
  endfunction

  initial begin
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    chk(on(), "R1 active in reset", int'(reset_lo), 0);
    chk(abort_lo == 1'b0, "R10 no strobe at power-on", int'(abort_lo), 0);
    rst_ni = 1'b1;
    count_active(n);
    chk(n == POR, "R1 power-on hold", n, POR);
    chk(abort_lo == 1'b0, "R10 no strobe at release", int'(abort_lo), 0);

    // R3 / R5 sweep over the three enabled codes
    for (int c = 0; c < 3; c++) begin
      wd_sel = 2'(c);
      count_inactive(n);
      chk(n == period(c), "R3 watchdog period", n, period(c));
      pulse_check("R5 expiry pulse length");
    end

    // R4 disabled
    wd_sel = 2'b11;
    ok = 1'b1;
    repeat (3 * WDL) begin @(negedge clk); if (on()) ok = 1'b0; end
    chk(ok, "R4 disabled never resets", int'(ok), 1);
    wd_sel = 2'b10;
    count_inactive(n);
    chk(n == WDS, "R4 fresh period after re-enable", n, WDS);
    pulse_check("R5 expiry pulse length");

    // R6 START kicks
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sda = 1'b0;
      repeat (10) begin @(negedge clk); if (on()) ok = 1'b0; end
      sda = 1'b1;
      repeat (5) begin @(negedge clk); if (on()) ok = 1'b0; end
    end
    chk(ok, "R6 periodic START keeps reset off", int'(ok), 1);
    sda = 1'b0;
    count_inactive(n);
    chk(n == WDS + 3, "R6 START restart latency", n, WDS + 3);
    sda = 1'b1;
    pulse_check("R5 expiry pulse length");

    // R7 non-START activity
    n = 0;
    while (!on() && n < 5000) begin
      case (n % 4)
        0: scl = 1'b0;
        1: sda = ~sda;
        2: scl = 1'b1;
        default: ;
      endcase
      n++;
      @(negedge clk);
    end
    chk(n == WDS, "R7 other activity ignored", n, WDS);
    scl = 1'b1;
    sda = 1'b1;
    pulse_check("R5 expiry pulse length");

    // R8 START during reset ignored
    count_inactive(n);
    chk(n == WDS, "R3 short period", n, WDS);
    @(negedge clk);
    repeat (4) @(negedge clk);
    sda = 1'b0;
    repeat (3) @(negedge clk);
    sda = 1'b1;
    count_active(n);
    chk(n == RST - 8, "R5 pulse with START inside", n, RST - 8);
    count_inactive(n);
    chk(n == WDS, "R8 START during reset ignored", n, WDS);

    // R9 low supply during watchdog pulse
    repeat (10) @(negedge clk);
    low = 1'b1;
    ok = 1'b1;
    repeat (4) begin @(negedge clk); if (abort_lo) ok = 1'b0; end
    chk(ok, "R10 no strobe while already active", int'(ok), 1);
    low = 1'b0;
    count_active(n);
    chk(n == POR, "R9 release restarts with power-on hold", n, POR);

    // R2 low supply from run state
    repeat (5) @(negedge clk);
    low = 1'b1;
    @(negedge clk);
    chk(on(), "R2 immediate assertion", int'(reset_lo), 0);
    chk(abort_lo == 1'b1, "R10 strobe on supply low", int'(abort_lo), 1);
    repeat (5) @(negedge clk);
    low = 1'b0;
    count_active(n);
    chk(n == POR, "R2 release after flag clear", n, POR);

    chk(pol_mismatch == 0, "R11 polarity variants", pol_mismatch, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule